// File: doc/BRIEF.md
# Three-Channel Grey-Code PWM Generator

The block turns three 5-bit colour intensity codes (red, green, blue) into three pulse-width-modulated output levels. Time is measured in grey-clock ticks, supplied as a one-cycle enable on the system clock. One shared period counter serves all three channels, so every channel that is lit switches on in the same cycle at the start of each period.

Two mappings are available, picked by a mode input. In the linear mapping the period is 128 ticks and each code step adds 4 ticks of on-time. In the expanded mapping the period is 256 ticks and the on-time follows a square-law curve, from 1 tick for code 1 up to the full 256 ticks for code 31. This gives fine resolution at low brightness. Codes are captured by a load strobe into a pending bank and applied only when a new period begins. Between loads the outputs repeat the same duty cycle on their own for as long as needed. A mode input that is not driven low (high, floating or unknown) selects the linear mapping.

Top module: `greypwm_rgb`

## Requirements
- R1: While reset is high, and after reset until codes are loaded, all three outputs are low and the period counter starts at the beginning of a period in linear mapping.
- R2: With `lin_sel` high the period is 128 grey-clock ticks and a channel with code c is high for exactly 4*c ticks per period (code 31 gives 124).
- R3: With `lin_sel` low the period is 256 ticks and a channel with code c is high for floor((c+1)^2/4) ticks per period: code 1 gives 1, code 2 gives 2, code 15 gives 64, code 30 gives 240, and code 31 gives 256, which means the output stays high.
- R4: Code 0 keeps a channel low throughout, in either mapping.
- R5: Codes present on the code inputs are captured in the cycle where `ld` is high. Without a further `ld`, the outputs keep the same duty cycle period after period.
- R6: Codes loaded partway through a period do not change the pulse already in progress. They take effect from the next period start.
- R7: The period counter advances only in cycles where `gclk_en` is high. While `gclk_en` stays low, all outputs hold their value.
- R8: A channel output can rise only in the clock cycle that follows a counter value of zero. This means all lit channels rise together.
- R9: A change of `lin_sel` takes effect only at a period boundary. The current pulse and period finish under the old mapping. Any value of `lin_sel` other than a driven 0 selects the linear mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| gclk_en | input | 1 | Grey-clock tick enable; each high cycle is one tick |
| lin_sel | input | 1 | 1 (or undriven) selects linear mapping, 0 selects square-law mapping |
| ld | input | 1 | Load strobe that captures the three codes |
| code_r | input | 5 | Red intensity code |
| code_g | input | 5 | Green intensity code |
| code_b | input | 5 | Blue intensity code |
| pwm_r | output | 1 | Red PWM output (registered) |
| pwm_g | output | 1 | Green PWM output (registered) |
| pwm_b | output | 1 | Blue PWM output (registered) |

## Verification
A load becomes visible only at the next period start. The outputs are registered one cycle behind the counter. For these reasons the checks do not sample a fixed number of cycles after each stimulus. After every load or mode change the bench waits for at least two of the longest periods. It then counts high samples over exactly one period, a count that does not depend on the phase. For the mid-period cases (R6, R9) the bench locks onto an observed rising edge. It then measures the width of the current pulse and the next one, and the spacing between rises. All sampling takes place on the falling clock edge.

// File: rtl/greypwm_pkg.sv
package greypwm_pkg;
  typedef enum logic {MAP_SQUARE = 1'b0, MAP_LINEAR = 1'b1} map_e;
  localparam int unsigned NCH = 3;
endpackage

// File: rtl/gp_period_ctr.sv
module gp_period_ctr
  import greypwm_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LIN_LAST = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  map_e             map_req,
  output logic [CNT_W-1:0] cnt,
  output map_e             map_q,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] SQ_LAST  = '1;
  localparam logic [CNT_W-1:0] LN_LAST  = CNT_W'(LIN_LAST);

  logic [CNT_W-1:0] last;
  assign last = (map_q == MAP_LINEAR) ? LN_LAST : SQ_LAST;
  assign wrap = tick && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      map_q <= MAP_LINEAR;
    end else if (tick) begin
      if (wrap) begin
        cnt   <= '0;
        map_q <= map_req;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_lin_range_r2: assert property (@(posedge clk) disable iff (rst)
    (map_q == MAP_LINEAR) |-> (cnt <= LN_LAST));
  p_tick_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
  p_map_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(map_q));
endmodule

// File: rtl/gp_code_bank.sv
module gp_code_bank
  import greypwm_pkg::*;
#(
  parameter int unsigned CODE_W = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ld,
  input  logic                         wrap,
  input  logic [NCH-1:0][CODE_W-1:0]   codes_in,
  output logic [NCH-1:0][CODE_W-1:0]   active
);
  logic [NCH-1:0][CODE_W-1:0] pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      active  <= '0;
    end else begin
      if (ld)   pending <= codes_in;
      if (wrap) active  <= pending;
    end
  end

  p_active_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(active));
  p_pending_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(pending));
endmodule

// File: rtl/gp_chan.sv
module gp_chan
  import greypwm_pkg::*;
#(
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LIN_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt,
  input  map_e              map_q,
  input  logic [CODE_W-1:0] code,
  output logic              out_q
);
  localparam int unsigned ON_W = CNT_W + 1;
  localparam int unsigned SQ_W = 2 * (CODE_W + 1);

  logic [CODE_W:0]   code_p1;
  logic [SQ_W-1:0]   sq;
  logic [ON_W-1:0]   on_lin;
  logic [ON_W-1:0]   on_sq;
  logic [ON_W-1:0]   on_time;

  assign code_p1 = {1'b0, code} + 1'b1;
  assign sq      = SQ_W'(code_p1) * SQ_W'(code_p1);
  assign on_sq   = ON_W'(sq >> 2);
  assign on_lin  = ON_W'(code) * ON_W'(LIN_STEP);
  assign on_time = (map_q == MAP_LINEAR) ? on_lin : on_sq;

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= ({1'b0, cnt} < on_time);
  end

  p_zero_dark_r4: assert property (@(posedge clk) disable iff (rst)
    (code == '0) |=> !out_q);
  p_full_on_r3: assert property (@(posedge clk) disable iff (rst)
    (map_q == MAP_SQUARE && code == '1) |=> out_q);
  p_rise_at_start_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(out_q) |-> ($past(cnt) == '0));
endmodule

// File: rtl/greypwm_rgb.sv
module greypwm_rgb
  import greypwm_pkg::*;
#(
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned LIN_LAST = 127,
  parameter int unsigned LIN_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gclk_en,
  input  logic              lin_sel,
  input  logic              ld,
  input  logic [CODE_W-1:0] code_r,
  input  logic [CODE_W-1:0] code_g,
  input  logic [CODE_W-1:0] code_b,
  output logic              pwm_r,
  output logic              pwm_g,
  output logic              pwm_b
);
  logic [CNT_W-1:0]           cnt;
  map_e                       map_q;
  map_e                       map_req;
  logic                       wrap;
  logic [NCH-1:0][CODE_W-1:0] codes_in;
  logic [NCH-1:0][CODE_W-1:0] active;
  logic [NCH-1:0]             outs;

  // Anything but a driven 0 (high, floating, unknown) picks linear mapping.
  assign map_req  = (lin_sel !== 1'b0) ? MAP_LINEAR : MAP_SQUARE;
  assign codes_in = {code_b, code_g, code_r};

  gp_period_ctr #(.CNT_W(CNT_W), .LIN_LAST(LIN_LAST)) u_ctr (
    .clk(clk), .rst(rst), .tick(gclk_en), .map_req(map_req),
    .cnt(cnt), .map_q(map_q), .wrap(wrap)
  );

  gp_code_bank #(.CODE_W(CODE_W)) u_bank (
    .clk(clk), .rst(rst), .ld(ld), .wrap(wrap),
    .codes_in(codes_in), .active(active)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    gp_chan #(.CODE_W(CODE_W), .CNT_W(CNT_W), .LIN_STEP(LIN_STEP)) u_ch (
      .clk(clk), .rst(rst), .cnt(cnt), .map_q(map_q),
      .code(active[i]), .out_q(outs[i])
    );
  end

  assign pwm_r = outs[0];
  assign pwm_g = outs[1];
  assign pwm_b = outs[2];

  p_reset_dark_r1: assert property (@(posedge clk)
    $past(rst) |-> (outs == '0));
endmodule

// File: tb/greypwm_rgb_test.sv
module greypwm_rgb_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gclk_en = 1'b1;
  logic lin_sel = 1'b1;
  logic ld = 1'b0;
  logic [4:0] code_r = '0, code_g = '0, code_b = '0;
  logic pwm_r, pwm_g, pwm_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  greypwm_rgb uut (
    .clk(clk), .rst(rst), .gclk_en(gclk_en), .lin_sel(lin_sel), .ld(ld),
    .code_r(code_r), .code_g(code_g), .code_b(code_b),
    .pwm_r(pwm_r), .pwm_g(pwm_g), .pwm_b(pwm_b)
  );

  // {linear, r, g, b, exp_r, exp_g, exp_b}
  localparam logic [42:0] VEC [6] = '{
    {1'b1, 5'd1,  5'd16, 5'd31, 9'd4,   9'd64,  9'd124},
    {1'b1, 5'd0,  5'd5,  5'd30, 9'd0,   9'd20,  9'd120},
    {1'b0, 5'd1,  5'd2,  5'd31, 9'd1,   9'd2,   9'd256},
    {1'b0, 5'd0,  5'd15, 5'd30, 9'd0,   9'd64,  9'd240},
    {1'b0, 5'd7,  5'd20, 5'd3,  9'd16,  9'd110, 9'd4},
    {1'b1, 5'd31, 5'd0,  5'd8,  9'd124, 9'd0,   9'd32}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [4:0] r, input logic [4:0] g, input logic [4:0] b);
    @(negedge clk);
    code_r = r; code_g = g; code_b = b; ld = 1'b1;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic measure(input int per, output int hr, output int hg, output int hb);
    hr = 0; hg = 0; hb = 0;
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      hr += int'(pwm_r); hg += int'(pwm_g); hb += int'(pwm_b);
    end
  endtask

  task automatic wait_rise_r();
    logic prev;
    prev = pwm_r;
    forever begin
      @(negedge clk);
      if (!prev && pwm_r) break;
      prev = pwm_r;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hr, hg, hb, w, per;
    logic [2:0] snap;
    // R1: reset state
    cyc(5);
    chk("R1 reset outputs", int'({pwm_r, pwm_g, pwm_b}), 0);
    rst = 1'b0;
    measure(300, hr, hg, hb);
    chk("R1 idle after reset", hr + hg + hb, 0);

    // Vector table: R2, R3, R4
    for (int v = 0; v < 6; v++) begin
      int p;
      lin_sel = VEC[v][42];
      load(VEC[v][41:37], VEC[v][36:32], VEC[v][31:27]);
      cyc(530);
      p = VEC[v][42] ? 128 : 256;
      measure(p, hr, hg, hb);
      chk(VEC[v][42] ? "R2 linear red"   : "R3 square red",   hr, int'(VEC[v][26:18]));
      chk(VEC[v][42] ? "R2 linear green" : "R3 square green", hg, int'(VEC[v][17:9]));
      chk(VEC[v][42] ? "R2 linear blue"  : "R3 square blue",  hb, int'(VEC[v][8:0]));
      if (v == 3) begin
        // R5: free-running without new load
        cyc(700);
        measure(256, hr, hg, hb);
        chk("R5 free-run repeat", hg * 1000 + hb, 64 * 1000 + 240);
        chk("R4 zero code stays dark", hr, 0);
      end
    end

    // R8: aligned rises, linear then square mapping
    lin_sel = 1'b1;
    load(5'd1, 5'd15, 5'd30);
    cyc(530);
    w = 0;
    for (int i = 0; i < 300; i++) begin
      logic [2:0] pv;
      pv = {pwm_r, pwm_g, pwm_b};
      @(negedge clk);
      if (|(~pv & {pwm_r, pwm_g, pwm_b}) && !(&(~pv & {pwm_r, pwm_g, pwm_b}))) w++;
    end
    chk("R8 edges aligned linear", w, 0);
    lin_sel = 1'b0;
    load(5'd1, 5'd2, 5'd29);
    cyc(530);
    w = 0;
    for (int i = 0; i < 600; i++) begin
      logic [2:0] pv;
      pv = {pwm_r, pwm_g, pwm_b};
      @(negedge clk);
      if (|(~pv & {pwm_r, pwm_g, pwm_b}) && !(&(~pv & {pwm_r, pwm_g, pwm_b}))) w++;
    end
    chk("R8 edges aligned square", w, 0);

    // R6: mid-period load, linear code 10 -> 20
    lin_sel = 1'b1;
    load(5'd10, 5'd10, 5'd10);
    cyc(530);
    wait_rise_r();
    w = 1;
    @(negedge clk); w++;
    code_r = 5'd20; ld = 1'b1;
    @(negedge clk); ld = 1'b0;
    if (pwm_r) w++;
    while (pwm_r) begin
      @(negedge clk);
      if (pwm_r) w++;
    end
    chk("R6 current pulse unchanged", w, 40);
    per = w;
    while (!pwm_r) begin @(negedge clk); per++; end
    chk("R6 period 128 between rises", per, 128);
    w = 1;
    @(negedge clk);
    while (pwm_r) begin w++; @(negedge clk); end
    chk("R6 next pulse uses new code", w, 80);

    // R9: mapping change mid-period, code 16 linear (64) -> square (72)
    load(5'd16, 5'd0, 5'd0);
    cyc(530);
    wait_rise_r();
    lin_sel = 1'b0;
    w = 1; per = 1;
    @(negedge clk);
    while (pwm_r) begin w++; per++; @(negedge clk); end
    chk("R9 pulse keeps old mapping", w, 64);
    while (!pwm_r) begin per++; @(negedge clk); end
    chk("R9 old period completes", per, 128);
    w = 1; per = 1;
    @(negedge clk);
    while (pwm_r) begin w++; per++; @(negedge clk); end
    chk("R9 new mapping pulse", w, 72);
    while (!pwm_r) begin per++; @(negedge clk); end
    chk("R9 new period length", per, 256);

    // R7: ticks paused, outputs hold
    cyc(30);
    @(negedge clk);
    gclk_en = 1'b0;
    @(negedge clk);
    snap = {pwm_r, pwm_g, pwm_b};
    w = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if ({pwm_r, pwm_g, pwm_b} != snap) w++;
    end
    chk("R7 outputs frozen without tick", w, 0);
    chk("R7 red held high mid-pulse", int'(snap[2]), 1);
    gclk_en = 1'b1;
    measure(256, hr, hg, hb);
    chk("R7 resumes with same duty", hr, 72);

    // R1: reset mid-operation clears outputs
    @(negedge clk);
    rst = 1'b1;
    cyc(3);
    chk("R1 reset clears outputs", int'({pwm_r, pwm_g, pwm_b}), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule